// File: doc/BRIEF.md
# Lane-Partitioned Saturating Adder

This block adds or subtracts two wide operands as a group of independent lanes. A mode input sets the lane width. With the default parameters the datapath is 64 bits wide, and the lanes can be 8, 16, 32 or 64 bits. All lanes are computed in the same clock cycle. Carries and borrows stop at every lane edge, so no lane affects its neighbour.

Each operation can wrap modulo the lane width or clamp to the lane's range. The operands are read as unsigned or as two's complement. An out-of-range result never raises a trap. In clamp mode the bound is produced and a flag is raised for the lane. Both the result and the flags are registered.

The datapath is built from `NUM_SEG` segments, each `SEG_W` bits wide. A lane covers a power-of-two count of neighbouring segments.

Top module: `simd_sat_adder`

## Requirements
- R1: The lane width is `SEG_W << lane_mode`, so mode 0 gives the narrowest lanes. Any mode value above log2(`NUM_SEG`) selects one lane across the whole datapath.
- R2: No carry crosses a lane boundary. With `sat_en`=0, each lane of `result` is (a + b) mod 2^w for that lane's bits, where w is the lane width.
- R3: With `do_sub`=1, each lane computes a − b. In wrap mode the result is taken mod 2^w.
- R4: With `sat_en`=1 and `is_signed`=1, a lane result above 2^(w−1)−1 becomes 2^(w−1)−1: the lane MSB is 0 and all other bits are 1.
- R5: With `sat_en`=1 and `is_signed`=1, a lane result below −2^(w−1) becomes −2^(w−1): the lane MSB is 1 and all other bits are 0.
- R6: With `sat_en`=1 and `is_signed`=0, an add above 2^w−1 gives all ones, and a subtract below zero gives zero.
- R7: `sat_flag` bit k belongs to segment k, which holds bits [k·SEG_W +: SEG_W]. The bit is 1 only when the lane containing that segment was clamped, so every bit of one lane carries the same value. With `sat_en`=0, all flags are 0.
- R8: `result` and `sat_flag` change only at the rising clock edge after the inputs are applied. A synchronous reset sets both to zero.
- R9: With `sat_en`=1, a lane whose exact result is in range produces the exact result and a flag of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | SEG_W*NUM_SEG | First operand (minuend for subtract) |
| op_b | input | SEG_W*NUM_SEG | Second operand |
| lane_mode | input | MODE_W | Lane width select: SEG_W << lane_mode |
| do_sub | input | 1 | 1 = subtract, 0 = add |
| is_signed | input | 1 | 1 = two's-complement lanes |
| sat_en | input | 1 | 1 = clamp, 0 = wrap |
| result | output | SEG_W*NUM_SEG | Registered lane results |
| sat_flag | output | NUM_SEG | Registered per-segment clamp flags |

## Verification
The bench builds the block with `SEG_W`=2 and `NUM_SEG`=4, which gives an 8-bit datapath with 2-, 4- and 8-bit lanes. All four mode codes are driven, including the out-of-range code that must fall back to one full lane. At this size, every combination of mode, add/subtract, signedness and clamp can be swept against all 256 values of one operand and a spread of the other. Every lane then reaches both clamp bounds, unsigned wrap-around in both directions, and the carry and borrow patterns that would leak across a lane edge. Before each clock edge the bench also confirms that the registered outputs still hold the previous result.

// File: rtl/simd_pkg.sv
package simd_pkg;

    typedef struct packed {
        logic sub;
        logic signd;
        logic sat;
    } lane_op_t;

    typedef enum logic [2:0] {
        CLAMP_NONE = 3'd0,
        CLAMP_ONES = 3'd1,
        CLAMP_ZERO = 3'd2,
        CLAMP_SMAX = 3'd3,
        CLAMP_SMIN = 3'd4
    } clamp_t;

    // Decide which bound a lane is forced to, from its overflow indications.
    function automatic clamp_t pick_clamp(lane_op_t op, logic s_ovf, logic u_ovf, logic a_sign);
        if (!op.sat) return CLAMP_NONE;
        if (op.signd) begin
            if (!s_ovf) return CLAMP_NONE;
            return a_sign ? CLAMP_SMIN : CLAMP_SMAX;
        end
        if (!u_ovf) return CLAMP_NONE;
        return op.sub ? CLAMP_ZERO : CLAMP_ONES;
    endfunction

endpackage

// File: rtl/simd_seg_adder.sv
module simd_seg_adder #(
    parameter  int SEG_W   = 8,
    parameter  int NUM_SEG = 8,
    localparam int LOG_SEG = $clog2(NUM_SEG),
    localparam int DATA_W  = SEG_W * NUM_SEG
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [DATA_W-1:0]  a,
    input  logic [DATA_W-1:0]  b,
    input  logic [LOG_SEG-1:0] lane_mask,
    input  logic               sub,
    output logic [DATA_W-1:0]  sum,
    output logic [NUM_SEG-1:0] s_ovf,
    output logic [NUM_SEG-1:0] u_ovf,
    output logic [NUM_SEG-1:0] a_sign
);

    logic [NUM_SEG-1:0] cout;
    logic [NUM_SEG-1:0] cin;
    logic [NUM_SEG-1:0] base;

    for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
        logic [SEG_W-1:0] a_seg;
        logic [SEG_W-1:0] b_seg;
        logic [SEG_W-1:0] b_eff;
        logic [SEG_W-1:0] s_seg;
        logic [SEG_W:0]   wide;

        assign a_seg   = a[s*SEG_W +: SEG_W];
        assign b_seg   = b[s*SEG_W +: SEG_W];
        assign b_eff   = b_seg ^ {SEG_W{sub}};
        assign base[s] = ((LOG_SEG'(s) & lane_mask) == '0);

        if (s == 0) begin : g_first
            assign cin[s] = sub;
        end else begin : g_rest
            // a lane's lowest segment restarts the chain
            assign cin[s] = base[s] ? sub : cout[s-1];
        end

        assign wide      = {1'b0, a_seg} + {1'b0, b_eff} + {{SEG_W{1'b0}}, cin[s]};
        assign s_seg     = wide[SEG_W-1:0];
        assign cout[s]   = wide[SEG_W];
        assign sum[s*SEG_W +: SEG_W] = s_seg;
        assign a_sign[s] = a_seg[SEG_W-1];
        assign s_ovf[s]  = (a_seg[SEG_W-1] == b_eff[SEG_W-1]) && (s_seg[SEG_W-1] != a_seg[SEG_W-1]);
        assign u_ovf[s]  = cout[s] ^ sub;

        // R2
        lane_iso_chk: assert property (@(posedge clk) disable iff (rst)
            base[s] |-> (s_seg == (sub ? SEG_W'(a_seg - b_seg) : SEG_W'(a_seg + b_seg))));
    end

endmodule

// File: rtl/simd_lane_sat.sv
module simd_lane_sat
    import simd_pkg::*;
#(
    parameter  int SEG_W   = 8,
    parameter  int NUM_SEG = 8,
    localparam int LOG_SEG = $clog2(NUM_SEG),
    localparam int DATA_W  = SEG_W * NUM_SEG
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [DATA_W-1:0]  sum,
    input  logic [NUM_SEG-1:0] s_ovf,
    input  logic [NUM_SEG-1:0] u_ovf,
    input  logic [NUM_SEG-1:0] a_sign,
    input  logic [LOG_SEG-1:0] lane_mask,
    input  lane_op_t           op,
    output logic [DATA_W-1:0]  res,
    output logic [NUM_SEG-1:0] flag
);

    for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
        logic [LOG_SEG-1:0] top_idx;
        logic               is_top;
        logic               is_base;
        clamp_t             kind;
        logic [SEG_W-1:0]   seg_in;
        logic [SEG_W-1:0]   seg_out;

        assign top_idx = LOG_SEG'(s) | lane_mask;
        assign is_top  = ((LOG_SEG'(s) & lane_mask) == lane_mask);
        assign is_base = ((LOG_SEG'(s) & lane_mask) == '0);
        assign seg_in  = sum[s*SEG_W +: SEG_W];
        // overflow state is only valid in the lane's top segment
        assign kind    = pick_clamp(op, s_ovf[top_idx], u_ovf[top_idx], a_sign[top_idx]);

        always_comb begin
            case (kind)
                CLAMP_ONES: seg_out = '1;
                CLAMP_ZERO: seg_out = '0;
                CLAMP_SMAX: seg_out = is_top ? {1'b0, {(SEG_W-1){1'b1}}} : '1;
                CLAMP_SMIN: seg_out = is_top ? {1'b1, {(SEG_W-1){1'b0}}} : '0;
                default:    seg_out = seg_in;
            endcase
        end

        assign res[s*SEG_W +: SEG_W] = seg_out;
        assign flag[s] = (kind != CLAMP_NONE);

        // R6
        uns_add_clamp_chk: assert property (@(posedge clk) disable iff (rst)
            (flag[s] && !op.signd && !op.sub) |-> (seg_out == '1));
        // R6
        uns_sub_clamp_chk: assert property (@(posedge clk) disable iff (rst)
            (flag[s] && !op.signd && op.sub) |-> (seg_out == '0));
        // R4 and R5: the clamp's sign follows operand a's sign
        sgn_clamp_dir_chk: assert property (@(posedge clk) disable iff (rst)
            (flag[s] && op.signd && is_top) |-> (seg_out[SEG_W-1] == a_sign[s]));

        if (s > 0) begin : g_uni
            // R7
            lane_flag_uni_chk: assert property (@(posedge clk) disable iff (rst)
                !is_base |-> (flag[s] == flag[s-1]));
        end
    end

endmodule

// File: rtl/simd_sat_adder.sv
module simd_sat_adder
    import simd_pkg::*;
#(
    parameter  int SEG_W   = 8,
    parameter  int NUM_SEG = 8,
    localparam int LOG_SEG = $clog2(NUM_SEG),
    localparam int MODE_W  = $clog2(LOG_SEG + 1),
    localparam int DATA_W  = SEG_W * NUM_SEG
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [DATA_W-1:0]  op_a,
    input  logic [DATA_W-1:0]  op_b,
    input  logic [MODE_W-1:0]  lane_mode,
    input  logic               do_sub,
    input  logic               is_signed,
    input  logic               sat_en,
    output logic [DATA_W-1:0]  result,
    output logic [NUM_SEG-1:0] sat_flag
);

    logic [LOG_SEG-1:0] lane_mask;
    lane_op_t           op;
    logic [DATA_W-1:0]  raw_sum;
    logic [DATA_W-1:0]  lane_res;
    logic [NUM_SEG-1:0] s_ovf;
    logic [NUM_SEG-1:0] u_ovf;
    logic [NUM_SEG-1:0] a_sign;
    logic [NUM_SEG-1:0] lane_flag;

    // segments per lane minus one; modes past the top saturate to full width
    always_comb begin
        lane_mask = '0;
        for (int i = 0; i < LOG_SEG; i++) begin
            if (int'(lane_mode) > i) lane_mask[i] = 1'b1;
        end
    end

    assign op = '{sub: do_sub, signd: is_signed, sat: sat_en};

    simd_seg_adder #(.SEG_W(SEG_W), .NUM_SEG(NUM_SEG)) u_add (
        .clk       (clk),
        .rst       (rst),
        .a         (op_a),
        .b         (op_b),
        .lane_mask (lane_mask),
        .sub       (do_sub),
        .sum       (raw_sum),
        .s_ovf     (s_ovf),
        .u_ovf     (u_ovf),
        .a_sign    (a_sign)
    );

    simd_lane_sat #(.SEG_W(SEG_W), .NUM_SEG(NUM_SEG)) u_sat (
        .clk       (clk),
        .rst       (rst),
        .sum       (raw_sum),
        .s_ovf     (s_ovf),
        .u_ovf     (u_ovf),
        .a_sign    (a_sign),
        .lane_mask (lane_mask),
        .op        (op),
        .res       (lane_res),
        .flag      (lane_flag)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result   <= '0;
            sat_flag <= '0;
        end else begin
            result   <= lane_res;
            sat_flag <= lane_flag;
        end
    end

    // R8
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (result == '0 && sat_flag == '0));
    // R7
    wrap_flag_chk: assert property (@(posedge clk) disable iff (rst)
        !sat_en |=> (sat_flag == '0));

endmodule

// File: tb/simd_sat_adder_tb_top.sv
module simd_sat_adder_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] a   = 8'h00;
    logic [7:0] b   = 8'h00;
    logic [1:0] md  = 2'd0;
    logic       sub = 1'b0;
    logic       sgn = 1'b0;
    logic       sat = 1'b0;
    logic [7:0] res;
    logic [3:0] flg;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    simd_sat_adder #(.SEG_W(2), .NUM_SEG(4)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .op_a      (a),
        .op_b      (b),
        .lane_mode (md),
        .do_sub    (sub),
        .is_signed (sgn),
        .sat_en    (sat),
        .result    (res),
        .sat_flag  (flg)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h (a=%0h b=%0h mode=%0d sub=%0d sgn=%0d sat=%0d)",
                     tag, act, exp, a, b, md, sub, sgn, sat);
        end
    endtask

    // Arithmetic reference: exact integer result per lane, then clamp or wrap.
    function automatic void model(input int av, input int bv, input int mode, input int s_sub,
                                  input int s_sgn, input int s_sat, output int r_out, output int f_out);
        int eff;
        int lw;
        int nl;
        int msk;
        eff   = (mode > 2) ? 2 : mode;
        lw    = 2 << eff;
        nl    = 8 / lw;
        msk   = (1 << lw) - 1;
        r_out = 0;
        f_out = 0;
        for (int i = 0; i < nl; i++) begin
            int ua;
            int ub;
            int va;
            int vb;
            int r;
            int lo;
            int hi;
            bit cl;
            ua = (av >> (i*lw)) & msk;
            ub = (bv >> (i*lw)) & msk;
            va = ua;
            vb = ub;
            cl = 1'b0;
            if (s_sgn != 0) begin
                if (((ua >> (lw-1)) & 1) != 0) va = ua - (1 << lw);
                if (((ub >> (lw-1)) & 1) != 0) vb = ub - (1 << lw);
                lo = -(1 << (lw-1));
                hi = (1 << (lw-1)) - 1;
            end else begin
                lo = 0;
                hi = msk;
            end
            r = (s_sub != 0) ? va - vb : va + vb;
            if (s_sat != 0 && r > hi) begin
                r = hi;
                cl = 1'b1;
            end else if (s_sat != 0 && r < lo) begin
                r = lo;
                cl = 1'b1;
            end
            r_out |= (r & msk) << (i*lw);
            if (cl) f_out |= ((1 << (lw/2)) - 1) << (i*lw/2);
        end
    endfunction

    initial begin
        int prev_r;
        int prev_f;
        // R8: reset clears outputs even with live inputs
        a   = 8'hA5;
        b   = 8'h5A;
        sat = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        check("R8 reset result", int'(res), 0);
        check("R8 reset flags", int'(flg), 0);
        prev_r = 0;
        prev_f = 0;
        for (int m = 0; m < 4; m++) begin
            for (int ctl = 0; ctl < 8; ctl++) begin
                for (int ia = 0; ia < 256; ia++) begin
                    for (int k = 0; k < 12; k++) begin
                        int er;
                        int ef;
                        string tag;
                        @(negedge clk);
                        rst = 1'b0;
                        a   = 8'(ia);
                        b   = 8'((k*83 + 29) & 255);
                        md  = 2'(m);
                        sub = ctl[0];
                        sgn = ctl[1];
                        sat = ctl[2];
                        model(ia, int'(b), m, ctl & 1, (ctl >> 1) & 1, (ctl >> 2) & 1, er, ef);
                        #2;
                        // R8: nothing moves before the edge
                        check("R8 hold result", int'(res), prev_r);
                        check("R8 hold flags", int'(flg), prev_f);
                        @(posedge clk);
                        #2;
                        if (m == 3)              tag = "R1 full-lane fallback";
                        else if (ctl[2] == 1'b0) tag = ctl[0] ? "R3 wrap sub" : "R2 wrap add";
                        else if (ef == 0)        tag = "R9 in-range";
                        else if (ctl[1])         tag = "R4/R5 signed clamp";
                        else                     tag = "R6 unsigned clamp";
                        check(tag, int'(res), er);
                        check("R7 flags", int'(flg), ef);
                        prev_r = er;
                        prev_f = ef;
                    end
                end
            end
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 160000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule